// File: doc/BRIEF.md
# Operand Address Generator

This block sits between instruction decode and the operand fetch stage of a 32-bit processor. For each ALU-class instruction it takes the 4-bit addressing mode, the 16-bit mode-specific field, the current values of the two source registers that the field names, and the optional trailing 32-bit word. From these it forms the right-hand operand source. That source is one of four kinds: an immediate value, a shifted register value, a memory address, or an indirect memory address. It also gives the base-register update that pre- and post-modify forms need, and a flag when the trailing word is consumed.

Requests enter on a valid/ready handshake and results leave on another. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result is registered and shows up with `out_valid` high on the next cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and no new request is taken. The register file and memory lie outside this block.

Field layout used by the block: bits [15:12] hold the first source index or the high part of a 9-bit displacement. Bits [11:8] hold the base register index. Bits [7:5] hold the access type. Bits [4:0] hold the low displacement, and bits [2:0] double as the shift count or the modify sub-code.

Top module: `eag_unit`

## Requirements
- R1: A request accepted on one clock edge yields `out_valid` high after the next edge. `in_ready` is low while `out_valid` is high and `out_ready` is low. In that state all outputs stay unchanged.
- R2: Mode 0 gives kind immediate (0) with value equal to the field zero-extended. Mode 1 gives the field with the upper 16 bits forced to ones.
- R3: Mode 2 gives kind 0 with field[11:0] sign-extended. Mode 3 sign-extends the 8-bit value {field[11:8], field[3:0]}. When that value is 0x80, the output is the trailing word instead and `out_ext_used` is 1.
- R4: Mode 4 gives kind register (1) with value R shifted left by field[2:0]. Mode 6 gives kind memory (2) with address S + (R << field[2:0]).
- R5: The access size comes from field[7:5]. Codes 0 and 1 give 1 byte, codes 2 and 3 give 2 bytes, and any other code gives 4 bytes. Displacements and modify steps are scaled by this size.
- R6: Mode 5 is memory through R, with sub-code field[2:0] set as follows. Code 0 adds one size and addresses the new value. Code 1 subtracts one size and addresses the new value. Code 2 addresses R and then adds one size. Code 3 addresses R and then subtracts one size. Codes 0 to 3 assert `out_wb_en` with the new R in `out_wb_val`. Other codes address R with no writeback. `out_wb_idx` equals field[11:8].
- R7: Modes 8, 9, 10 and 11 address R + (field[4:0] + 0, 32, 64 or 96) × size.
- R8: Mode 7 addresses R + (field[4:0] | 0xFFFFFFE0) × size. When field[4:0] is zero, the address is R plus the trailing word and `out_ext_used` is 1.
- R9: Modes 12 and 13 address R + (d9 + 0 or 512) × size, where d9 = {field[15:12], field[4:0]}. Mode 14 gives kind indirect (3) at R + d9 × size. When field[4:0] is 0x1F, mode 14 uses R plus the trailing word instead and sets `out_ext_used`.
- R10: Mode 15 sets `out_illegal` and never asserts `out_wb_en`.
- R11: During reset and right after it, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_mode | input | 4 | Addressing mode |
| in_field | input | 16 | Mode-specific instruction field |
| in_s_val | input | 32 | Value of first source register |
| in_r_val | input | 32 | Value of base/second source register |
| in_ext_word | input | 32 | Trailing 32-bit instruction word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_kind | output | 2 | 0 immediate, 1 register, 2 memory, 3 indirect |
| out_value | output | 32 | Immediate, register value or address |
| out_ext_used | output | 1 | Trailing word consumed |
| out_wb_en | output | 1 | Base register update required |
| out_wb_idx | output | 4 | Base register index |
| out_wb_val | output | 32 | New base register value |
| out_illegal | output | 1 | Reserved mode seen |

## Verification
Every cycle, the assertions check the handshake: outputs hold and the input is blocked while the consumer stalls, and no result appears without a request. They also check that writeback happens only for memory-kind results and never alongside the illegal flag, and that a register-kind result never claims the trailing word. The arithmetic of each mode can only be shown by the directed scenarios. These cover the size scaling, the page offsets, the negative displacements, the escape values, and the ordering of pre- and post-modify addresses against the written-back base.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int XLEN   = 32;
  localparam int FLD_W  = 16;
  localparam int MODE_W = 4;
  localparam int IDX_W  = 4;

  typedef enum logic [1:0] {
    K_IMM = 2'd0,
    K_REG = 2'd1,
    K_MEM = 2'd2,
    K_IND = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [XLEN-1:0]   value;
    logic              ext_used;
    logic              wb_en;
    logic [IDX_W-1:0]  wb_idx;
    logic [XLEN-1:0]   wb_val;
    logic              illegal;
  } eag_res_t;

  // log2 of access size from type code
  function automatic logic [1:0] size_log(input logic [2:0] tcode);
    case (tcode)
      3'd0, 3'd1: size_log = 2'd0;
      3'd2, 3'd3: size_log = 2'd1;
      default:    size_log = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/eag_decode.sv
module eag_decode
  import eag_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [FLD_W-1:0]  fld,
  input  logic [XLEN-1:0]   s_val,
  input  logic [XLEN-1:0]   r_val,
  input  logic [XLEN-1:0]   ext_word,
  output eag_res_t          res
);
  logic [1:0]      sz;
  logic [4:0]      d5;
  logic [8:0]      d9;
  logic [7:0]      imm8;
  logic [2:0]      sub;
  logic [XLEN-1:0] step;
  logic [XLEN-1:0] r_inc;
  logic [XLEN-1:0] r_dec;

  assign sz    = size_log(fld[7:5]);
  assign d5    = fld[4:0];
  assign d9    = {fld[15:12], fld[4:0]};
  assign imm8  = {fld[11:8], fld[3:0]};
  assign sub   = fld[2:0];
  assign step  = 32'd1 << sz;
  assign r_inc = r_val + step;
  assign r_dec = r_val - step;

  always_comb begin
    res          = '0;
    res.kind     = K_MEM;
    res.wb_idx   = fld[11:8];
    res.wb_val   = r_val;
    case (mode)
      4'h0: begin
        res.kind  = K_IMM;
        res.value = {16'h0000, fld};
      end
      4'h1: begin
        res.kind  = K_IMM;
        res.value = {16'hFFFF, fld};
      end
      4'h2: begin
        res.kind  = K_IMM;
        res.value = {{20{fld[11]}}, fld[11:0]};
      end
      4'h3: begin
        res.kind = K_IMM;
        if (imm8 == 8'h80) begin
          res.value    = ext_word;
          res.ext_used = 1'b1;
        end else begin
          res.value = {{24{imm8[7]}}, imm8};
        end
      end
      4'h4: begin
        res.kind  = K_REG;
        res.value = r_val << fld[2:0];
      end
      4'h5: begin
        case (sub)
          3'd0: begin res.value = r_inc; res.wb_en = 1'b1; res.wb_val = r_inc; end
          3'd1: begin res.value = r_dec; res.wb_en = 1'b1; res.wb_val = r_dec; end
          3'd2: begin res.value = r_val; res.wb_en = 1'b1; res.wb_val = r_inc; end
          3'd3: begin res.value = r_val; res.wb_en = 1'b1; res.wb_val = r_dec; end
          default: res.value = r_val;
        endcase
      end
      4'h6: res.value = s_val + (r_val << fld[2:0]);
      4'h7: begin
        if (d5 == 5'd0) begin
          res.value    = r_val + ext_word;
          res.ext_used = 1'b1;
        end else begin
          res.value = r_val + ({27'h7FFFFFF, d5} << sz);
        end
      end
      4'h8, 4'h9, 4'hA, 4'hB:
        res.value = r_val + ({25'd0, mode[1:0], d5} << sz);
      4'hC, 4'hD:
        res.value = r_val + ({22'd0, mode[0], d9} << sz);
      4'hE: begin
        res.kind = K_IND;
        if (d5 == 5'h1F) begin
          res.value    = r_val + ext_word;
          res.ext_used = 1'b1;
        end else begin
          res.value = r_val + ({23'd0, d9} << sz);
        end
      end
      default: begin
        res.kind    = K_IMM;
        res.illegal = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/eag_outreg.sv
module eag_outreg
  import eag_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  eag_res_t in_res,
  output logic     out_valid,
  input  logic     out_ready,
  output eag_res_t out_res
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_res   <= in_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/eag_unit.sv
module eag_unit
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MODE_W-1:0] in_mode,
  input  logic [FLD_W-1:0]  in_field,
  input  logic [XLEN-1:0]   in_s_val,
  input  logic [XLEN-1:0]   in_r_val,
  input  logic [XLEN-1:0]   in_ext_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [XLEN-1:0]   out_value,
  output logic              out_ext_used,
  output logic              out_wb_en,
  output logic [IDX_W-1:0]  out_wb_idx,
  output logic [XLEN-1:0]   out_wb_val,
  output logic              out_illegal
);
  eag_res_t dec_res;
  eag_res_t reg_res;

  eag_decode u_dec (
    .mode     (in_mode),
    .fld      (in_field),
    .s_val    (in_s_val),
    .r_val    (in_r_val),
    .ext_word (in_ext_word),
    .res      (dec_res)
  );

  eag_outreg u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_res    (dec_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_res   (reg_res)
  );

  assign out_kind     = reg_res.kind;
  assign out_value    = reg_res.value;
  assign out_ext_used = reg_res.ext_used;
  assign out_wb_en    = reg_res.wb_en;
  assign out_wb_idx   = reg_res.wb_idx;
  assign out_wb_val   = reg_res.wb_val;
  assign out_illegal  = reg_res.illegal;
endmodule

// File: rtl/eag_unit_chk.sv
module eag_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [1:0]  out_kind,
  input logic [31:0] out_value,
  input logic        out_ext_used,
  input logic        out_wb_en,
  input logic        out_illegal
);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_value) && $stable(out_kind));

  a_r1_block: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !out_valid |=> !out_valid);

  a_r10_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_wb_en);

  a_r6_wb_mem: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wb_en |-> out_kind == 2'd2);

  a_r3_ext_kind: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ext_used |-> out_kind != 2'd1);
endmodule

bind eag_unit eag_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_kind     (out_kind),
  .out_value    (out_value),
  .out_ext_used (out_ext_used),
  .out_wb_en    (out_wb_en),
  .out_illegal  (out_illegal)
);

// File: tb/test_eag_unit.sv
module test_eag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_mode = '0;
  logic [15:0] in_field = '0;
  logic [31:0] in_s_val = '0;
  logic [31:0] in_r_val = '0;
  logic [31:0] in_ext_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_kind;
  logic [31:0] out_value;
  logic        out_ext_used;
  logic        out_wb_en;
  logic [3:0]  out_wb_idx;
  logic [31:0] out_wb_val;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  eag_unit i_eag_unit (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, accepted at next posedge, result sampled at following negedge
  task automatic issue(input logic [3:0] m, input logic [15:0] f,
                       input logic [31:0] s, input logic [31:0] r, input logic [31:0] x);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_field = f;
    in_s_val = s; in_r_val = r; in_ext_word = x;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_res(input string tag, input logic [1:0] k, input logic [31:0] v,
                            input logic xu, input logic we, input logic [31:0] wv,
                            input logic ill);
    chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " kind"}, {30'd0, out_kind}, {30'd0, k});
    chk({tag, " value"}, out_value, v);
    chk({tag, " ext"}, {31'd0, out_ext_used}, {31'd0, xu});
    chk({tag, " wb_en"}, {31'd0, out_wb_en}, {31'd0, we});
    if (we) chk({tag, " wb_val"}, out_wb_val, wv);
    chk({tag, " illegal"}, {31'd0, out_illegal}, {31'd0, ill});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R1 in_ready idle", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_imm();
    issue(4'h0, 16'h1234, 0, 0, 0);  expect_res("R2 mode0", 2'd0, 32'h00001234, 0, 0, 0, 0);
    issue(4'h1, 16'h0005, 0, 0, 0);  expect_res("R2 mode1", 2'd0, 32'hFFFF0005, 0, 0, 0, 0);
    issue(4'h2, 16'h0800, 0, 0, 0);  expect_res("R3 mode2", 2'd0, 32'hFFFFF800, 0, 0, 0, 0);
    issue(4'h3, 16'h0F0E, 0, 0, 0);  expect_res("R3 mode3", 2'd0, 32'hFFFFFFFE, 0, 0, 0, 0);
    issue(4'h3, 16'h0800, 0, 0, 32'hDEADBEEF);
    expect_res("R3 mode3 escape", 2'd0, 32'hDEADBEEF, 1, 0, 0, 0);
  endtask

  task automatic t_reg();
    issue(4'h4, 16'h0003, 0, 32'h10, 0);
    expect_res("R4 mode4", 2'd1, 32'h80, 0, 0, 0, 0);
    issue(4'h6, 16'h0002, 32'h1000, 32'h5, 0);
    expect_res("R4 mode6", 2'd2, 32'h1014, 0, 0, 0, 0);
  endtask

  task automatic t_modify();
    issue(4'h5, 16'h0740, 0, 32'h100, 0);  // short, pre-inc, R idx 7
    expect_res("R6 preinc R5 short", 2'd2, 32'h102, 0, 1, 32'h102, 0);
    chk("R6 wb_idx", {28'd0, out_wb_idx}, 32'd7);
    issue(4'h5, 16'h0083, 0, 32'h100, 0);  // int, post-dec
    expect_res("R6 postdec R5 int", 2'd2, 32'h100, 0, 1, 32'hFC, 0);
    issue(4'h5, 16'h0021, 0, 32'h100, 0);  // byte, pre-dec
    expect_res("R6 predec R5 byte", 2'd2, 32'hFF, 0, 1, 32'hFF, 0);
    issue(4'h5, 16'h0042, 0, 32'h100, 0);  // short, post-inc
    expect_res("R6 postinc R5 short", 2'd2, 32'h100, 0, 1, 32'h102, 0);
    issue(4'h5, 16'h0084, 0, 32'h100, 0);  // plain
    expect_res("R6 plain", 2'd2, 32'h100, 0, 0, 0, 0);
  endtask

  task automatic t_pages();
    issue(4'h9, 16'h0083, 0, 32'h2000, 0);
    expect_res("R7 mode9 int", 2'd2, 32'h2000 + (3 + 32) * 4, 0, 0, 0, 0);
    issue(4'hB, 16'h0021, 0, 32'h2000, 0);
    expect_res("R7 modeB byte", 2'd2, 32'h2000 + (1 + 96), 0, 0, 0, 0);
    issue(4'h8, 16'h005F, 0, 32'h2000, 0);
    expect_res("R7 mode8 short", 2'd2, 32'h2000 + 31 * 2, 0, 0, 0, 0);
    issue(4'hA, 16'h00A2, 0, 32'h2000, 0);  // type 5 -> 4 bytes
    expect_res("R5 modeA type5", 2'd2, 32'h2000 + (2 + 64) * 4, 0, 0, 0, 0);
  endtask

  task automatic t_negative();
    issue(4'h7, 16'h009F, 0, 32'h2000, 0);
    expect_res("R8 mode7 -1*4", 2'd2, 32'h1FFC, 0, 0, 0, 0);
    issue(4'h7, 16'h0041, 0, 32'h2000, 0);
    expect_res("R8 mode7 -31*2", 2'd2, 32'h2000 - 62, 0, 0, 0, 0);
    issue(4'h7, 16'h0080, 0, 32'h2000, 32'h30);
    expect_res("R8 mode7 escape", 2'd2, 32'h2030, 1, 0, 0, 0);
  endtask

  task automatic t_long();
    issue(4'hC, 16'h1042, 0, 32'h2000, 0);
    expect_res("R9 modeC", 2'd2, 32'h2000 + 34 * 2, 0, 0, 0, 0);
    issue(4'hD, 16'h0021, 0, 32'h2000, 0);
    expect_res("R9 modeD", 2'd2, 32'h2000 + 513, 0, 0, 0, 0);
    issue(4'hE, 16'h1081, 0, 32'h2000, 0);
    expect_res("R9 modeE", 2'd3, 32'h2000 + 33 * 4, 0, 0, 0, 0);
    issue(4'hE, 16'h009F, 0, 32'h2000, 32'h500);
    expect_res("R9 modeE escape", 2'd3, 32'h2500, 1, 0, 0, 0);
  endtask

  task automatic t_illegal();
    issue(4'hF, 16'h0040, 0, 32'h100, 0);
    expect_res("R10 modeF", 2'd0, out_value, 0, 0, 0, 1);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_mode = 4'h0; in_field = 16'h00AA;
    @(negedge clk);
    in_field = 16'h00BB;  // second request held off
    chk("R1 in_ready low on stall", {31'd0, in_ready}, 32'd0);
    chk("R1 first value", out_value, 32'hAA);
    @(negedge clk);
    @(negedge clk);
    chk("R1 value held", out_value, 32'hAA);
    chk("R1 valid held", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 second value after drain", out_value, 32'hBB);
    @(negedge clk);
    chk("R1 drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_imm();
    t_reg();
    t_modify();
    t_pages();
    t_negative();
    t_long();
    t_illegal();
    t_backpressure();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule